// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between a 32-bit register datapath and a data memory that is addressed by byte but organised in words. On the store side it takes the effective address, an access size and the register value, and in the same cycle it produces the word address, the write word with the source bytes steered onto the correct lanes, and one write enable per byte lane. Only the low byte or halfword of the register is written for narrow stores.

On the load side the request's low address bits, size and extension flag are registered. In the following cycle, when the memory returns its read word, the unit selects the addressed lanes and widens them to 32 bits. It sign-extends or zero-extends according to the request. Lane placement is big-endian: the byte at address offset 0 occupies the most significant lane. A word access that is not on a 4-byte boundary, a halfword access on an odd address, or the reserved size code raises a misalignment flag. The flag suppresses every byte enable and the load result.

Top module: `lsu_lane_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ld_valid` is cleared. With no request pending, `mem_be` is 0 and `misalign` is 0.
- R2: Lanes are big-endian. Byte offset k (address bits 1:0) occupies data bits [31-8k : 24-8k]. A halfword at offset 0 occupies bits 31:16, and one at offset 2 occupies bits 15:0. `mem_be[i]` enables data bits [8i+7 : 8i], so offset 0 corresponds to `mem_be[3]`.
- R3: A load with `req_sext`=1 and size byte (code 0) or halfword (code 1) copies bit 7 or bit 15 of the selected value into all higher bits of `ld_data`.
- R4: A load with `req_sext`=0 and size byte or halfword fills all higher bits of `ld_data` with zeros.
- R5: A word load (size code 2) returns `mem_rdata` unchanged, regardless of `req_sext`.
- R6: An accepted load (`req_valid`=1, `req_store`=0, no misalignment) raises `ld_valid` in the next cycle. In that cycle `ld_data` is formed combinationally from `mem_rdata` and the registered request fields.
- R7: A valid, aligned byte store drives `req_st_data[7:0]` onto the addressed lane and sets exactly one enable, `mem_be[3-offset]`.
- R8: A valid, aligned halfword store drives `req_st_data[15:0]` onto the addressed half. It sets `mem_be`=4'b1100 at offset 0 and 4'b0011 at offset 2.
- R9: A valid, aligned word store drives `req_st_data` unchanged and sets `mem_be`=4'b1111.
- R10: A valid word access with nonzero address bits 1:0, or a valid halfword access with address bit 0 set, raises `misalign` in the same cycle. It forces `mem_be` to 0 and produces no `ld_valid`.
- R11: The reserved size code 3 is treated as misaligned for any address.
- R12: `mem_word_addr` equals `req_addr[31:2]`. Loads never assert any `mem_be` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_sext | input | 1 | Load result sign-extended when 1, zero-extended when 0 |
| req_addr | input | 32 | Effective byte address |
| req_st_data | input | 32 | Register value to be stored |
| mem_rdata | input | 32 | Memory read word, valid the cycle after a load request |
| mem_word_addr | output | 30 | Word address to memory |
| mem_wdata | output | 32 | Write word with bytes placed on lanes |
| mem_be | output | 4 | Per-lane write enable |
| misalign | output | 1 | Misaligned or reserved-size request flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The sign and zero extension properties assume that `mem_rdata` is stable across the cycle in which `ld_valid` is high, because the result is formed combinationally from it. The load-valid properties assume that a request lasts exactly one cycle and is sampled at that cycle's edge. The stimulus drives every request for a single cycle, changes inputs only on the falling edge, and presents the read word right after the rising edge that registers the load. This keeps the read word steady through the cycle in which the result is sampled.

// File: rtl/lsu_pkg.sv
// Package: shared encodings for the load/store lane unit.
// Assumes a byte width of 8 bits and a two-bit size code.
package lsu_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } lsu_size_e;
endpackage

// File: rtl/lsu_align_check.sv
// Module: lsu_align_check
// Flags a request whose address offset does not suit its size, or whose
// size code is reserved. Assumes OFF_W >= 2 (data at least 32 bits).
module lsu_align_check
    import lsu_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             req_valid,
    input  logic [1:0]       req_size,
    input  logic [OFF_W-1:0] off,
    output logic             misalign
);
    logic bad;

    // Decide alignment legality from size and offset.
    always_comb begin
        case (lsu_size_e'(req_size))
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = |off;
            default: bad = 1'b1;
        endcase
    end

    assign misalign = req_valid & bad;
endmodule

// File: rtl/lsu_store_lanes.sv
// Module: lsu_store_lanes
// Places the low byte, low halfword or full register onto big-endian lanes
// and produces per-lane write enables. Assumes the offset is already legal
// for the size whenever en is high; en low forces all enables off.
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic                     en,
    input  logic [1:0]               size,
    input  logic [OFF_W-1:0]         off,
    input  logic [DATA_W-1:0]        src,
    output logic [DATA_W-1:0]        wdata,
    output logic [DATA_W/LANE_W-1:0] be
);
    localparam int NB = DATA_W / LANE_W;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        localparam int HI = DATA_W - 1 - LANE_W * k;
        logic [LANE_W-1:0] d;
        logic              e;

        // Choose this lane's data and enable for the current size.
        always_comb begin
            case (lsu_size_e'(size))
                SZ_BYTE: begin
                    d = src[LANE_W-1:0];
                    e = (off == OFF_W'(k));
                end
                SZ_HALF: begin
                    d = (k % 2 == 0) ? src[2*LANE_W-1:LANE_W] : src[LANE_W-1:0];
                    e = (off[OFF_W-1:1] == (OFF_W-1)'(k / 2));
                end
                default: begin
                    d = src[HI -: LANE_W];
                    e = 1'b1;
                end
            endcase
        end

        assign wdata[HI -: LANE_W] = d;
        assign be[NB-1-k]          = en & e;
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Module: lsu_load_extract
// Selects the addressed byte or halfword from a big-endian read word and
// widens it with sign or zero fill. Assumes registered, aligned offsets.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic [1:0]        size,
    input  logic              sext,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);
    localparam int NB = DATA_W / LANE_W;

    logic [LANE_W-1:0]   lane [NB];
    logic [LANE_W-1:0]   byte_v;
    logic [2*LANE_W-1:0] half_v;
    logic [OFF_W-1:0]    hi_idx;
    logic [OFF_W-1:0]    lo_idx;

    for (genvar k = 0; k < NB; k++) begin : g_split
        assign lane[k] = rdata[DATA_W-1-LANE_W*k -: LANE_W];
    end

    // Pick the addressed lanes and apply the extension.
    always_comb begin
        hi_idx = {off[OFF_W-1:1], 1'b0};
        lo_idx = {off[OFF_W-1:1], 1'b1};
        byte_v = lane[off];
        half_v = {lane[hi_idx], lane[lo_idx]};
        case (lsu_size_e'(size))
            SZ_BYTE: data = {{(DATA_W-LANE_W){sext & byte_v[LANE_W-1]}}, byte_v};
            SZ_HALF: data = {{(DATA_W-2*LANE_W){sext & half_v[2*LANE_W-1]}}, half_v};
            default: data = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_lane_unit.sv
// Module: lsu_lane_unit (top)
// Store path is combinational from the request. Load path registers the
// offset, size and extension flag, then extracts from the read word that
// memory returns one cycle later. Assumes one-cycle request pulses.
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_store,
    input  logic [1:0]                 req_size,
    input  logic                       req_sext,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_st_data,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_word_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic [DATA_W/8-1:0]        mem_be,
    output logic                       misalign,
    output logic                       ld_valid,
    output logic [DATA_W-1:0]          ld_data
);
    localparam int NB    = DATA_W / LANE_W;
    localparam int OFF_W = $clog2(NB);

    logic [OFF_W-1:0] req_off;
    logic             st_en;
    logic             ld_accept;
    logic             ld_valid_q;
    logic [OFF_W-1:0] ld_off_q;
    logic [1:0]       ld_size_q;
    logic             ld_sext_q;

    assign req_off       = req_addr[OFF_W-1:0];
    assign mem_word_addr = req_addr[ADDR_W-1:OFF_W];

    lsu_align_check #(.OFF_W(OFF_W)) u_align (
        .req_valid (req_valid),
        .req_size  (req_size),
        .off       (req_off),
        .misalign  (misalign)
    );

    assign st_en     = req_valid & req_store & ~misalign;
    assign ld_accept = req_valid & ~req_store & ~misalign;

    lsu_store_lanes #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_store (
        .en    (st_en),
        .size  (req_size),
        .off   (req_off),
        .src   (req_st_data),
        .wdata (mem_wdata),
        .be    (mem_be)
    );

    // Capture the load request fields for the next cycle's extraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid_q <= 1'b0;
            ld_off_q   <= '0;
            ld_size_q  <= 2'd0;
            ld_sext_q  <= 1'b0;
        end else begin
            ld_valid_q <= ld_accept;
            if (ld_accept) begin
                ld_off_q  <= req_off;
                ld_size_q <= req_size;
                ld_sext_q <= req_sext;
            end
        end
    end

    lsu_load_extract #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_load (
        .size  (ld_size_q),
        .sext  (ld_sext_q),
        .off   (ld_off_q),
        .rdata (mem_rdata),
        .data  (ld_data)
    );

    assign ld_valid = ld_valid_q;
endmodule

// File: rtl/lsu_lane_checker.sv
// Module: lsu_lane_checker
// Protocol properties for lsu_lane_unit, attached by bind below.
module lsu_lane_checker #(
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_store,
    input logic [1:0]           req_size,
    input logic                 req_sext,
    input logic [DATA_W/8-1:0]  mem_be,
    input logic                 misalign,
    input logic                 ld_valid,
    input logic [DATA_W-1:0]    ld_data
);
    assert_be_off_when_misaligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == '0));

    assert_no_result_after_misalign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !ld_valid);

    assert_result_follows_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && !misalign) |=> ld_valid);

    assert_reserved_size_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |-> misalign);

    assert_byte_store_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd0) |-> ($countones(mem_be) == 1));

    assert_load_no_enables_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_store) |-> (mem_be == '0));

    assert_byte_sign_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && $past(req_sext) && $past(req_size) == 2'd0)
        |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));

    assert_byte_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !$past(req_sext) && $past(req_size) == 2'd0)
        |-> (ld_data[DATA_W-1:8] == '0));

    assert_half_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !$past(req_sext) && $past(req_size) == 2'd1)
        |-> (ld_data[DATA_W-1:16] == '0));
endmodule

bind lsu_lane_unit lsu_lane_checker #(.DATA_W(DATA_W)) u_lane_checker (.*);

// File: tb/tb_lsu_lane_unit.sv
module tb_lsu_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_sext;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_st_data, mem_rdata;
    logic [29:0] mem_word_addr;
    logic [31:0] mem_wdata, ld_data;
    logic [3:0]  mem_be;
    logic        misalign, ld_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lsu_lane_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_sext(req_sext), .req_addr(req_addr),
        .req_st_data(req_st_data), .mem_rdata(mem_rdata),
        .mem_word_addr(mem_word_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_load(input logic [31:0] rd, input logic [1:0] off,
                                             input logic [1:0] sz, input logic sx);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'(rd >> (8 * (3 - off)));
        h = 16'(rd >> (16 * (1 - off[1])));
        if (sz == 2'd0) return sx ? 32'(signed'(b)) : {24'd0, b};
        if (sz == 2'd1) return sx ? 32'(signed'(h)) : {16'd0, h};
        return rd;
    endfunction

    task automatic idle();
        req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0; req_sext = 1'b0;
        req_addr = '0; req_st_data = '0;
    endtask

    // Issue one load, then present the read word and check the result.
    task automatic run_load(input string req, input logic [31:0] addr, input logic [1:0] sz,
                            input logic sx, input logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_size = sz; req_sext = sx; req_addr = addr;
        #1 check("R12 load enables", {28'd0, mem_be}, 32'd0);
        @(posedge clk);
        #1 idle(); mem_rdata = rd;
        @(negedge clk);
        check({req, " valid"}, {31'd0, ld_valid}, 32'd1);
        check(req, ld_data, exp_load(rd, addr[1:0], sz, sx));
    endtask

    // Issue one store and check lanes and enables in the same cycle.
    task automatic run_store(input string req, input logic [31:0] addr, input logic [1:0] sz,
                             input logic [31:0] src, input logic [3:0] exp_be,
                             input logic [31:0] exp_w);
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b1; req_size = sz; req_addr = addr; req_st_data = src;
        #1;
        check({req, " be"}, {28'd0, mem_be}, {28'd0, exp_be});
        check({req, " data"}, mem_wdata & {{8{exp_be[3]}}, {8{exp_be[2]}}, {8{exp_be[1]}}, {8{exp_be[0]}}}, exp_w);
        check({req, " misalign"}, {31'd0, misalign}, 32'd0);
        check("R12 word addr", {2'd0, mem_word_addr}, addr >> 2);
        @(negedge clk); idle();
    endtask

    // Issue a misaligned access and check flag, enables and load result.
    task automatic run_bad(input string req, input logic [31:0] addr, input logic [1:0] sz,
                           input logic st);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_addr = addr; req_st_data = 32'hFFFF_FFFF;
        #1;
        check({req, " flag"}, {31'd0, misalign}, 32'd1);
        check({req, " be"}, {28'd0, mem_be}, 32'd0);
        @(posedge clk);
        #1 idle();
        @(negedge clk);
        check({req, " no result"}, {31'd0, ld_valid}, 32'd0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(); mem_rdata = '0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ld_valid", {31'd0, ld_valid}, 32'd0);
        check("R1 be", {28'd0, mem_be}, 32'd0);
        check("R1 misalign", {31'd0, misalign}, 32'd0);
        rst_n = 1'b1;

        for (int o = 0; o < 4; o++) begin
            run_load("R2 R3 byte signed", 32'h100 + o, 2'd0, 1'b1, 32'h807F_01FF);
            run_load("R2 R4 byte unsigned", 32'h100 + o, 2'd0, 1'b0, 32'h807F_01FF);
        end
        run_load("R2 R3 half signed off0", 32'h200, 2'd1, 1'b1, 32'h807F_01FF);
        run_load("R2 R3 half signed off2", 32'h202, 2'd1, 1'b1, 32'h01FF_9234);
        run_load("R2 R4 half unsigned off0", 32'h200, 2'd1, 1'b0, 32'h807F_01FF);
        run_load("R2 R4 half unsigned off2", 32'h202, 2'd1, 1'b0, 32'h01FF_9234);
        run_load("R5 R6 word", 32'h300, 2'd2, 1'b1, 32'hDEAD_BEEF);

        for (int o = 0; o < 4; o++)
            run_store("R2 R7 byte store", 32'h400 + o, 2'd0, 32'hAABB_CCDD,
                      4'b1000 >> o, 32'hDDDD_DDDD & ({8'hFF, 24'd0} >> (8 * o)));
        run_store("R8 half store off0", 32'h500, 2'd1, 32'hAABB_CCDD, 4'b1100, 32'hCCDD_0000);
        run_store("R8 half store off2", 32'h502, 2'd1, 32'hAABB_CCDD, 4'b0011, 32'h0000_CCDD);
        run_store("R9 word store", 32'h604, 2'd2, 32'h1234_5678, 4'b1111, 32'h1234_5678);

        for (int o = 1; o < 4; o++) begin
            run_bad("R10 word store", 32'h700 + o, 2'd2, 1'b1);
            run_bad("R10 word load", 32'h700 + o, 2'd2, 1'b0);
        end
        run_bad("R10 half store off1", 32'h801, 2'd1, 1'b1);
        run_bad("R10 half load off3", 32'h803, 2'd1, 1'b0);
        run_bad("R11 reserved size store", 32'h900, 2'd3, 1'b1);
        run_bad("R11 reserved size load", 32'h900, 2'd3, 1'b0);

        @(negedge clk);
        req_store = 1'b1; req_size = 2'd2; req_addr = 32'h3;
        #1;
        check("R1 idle be", {28'd0, mem_be}, 32'd0);
        check("R1 idle misalign", {31'd0, misalign}, 32'd0);
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule